// File: doc/BRIEF.md
# Wide Register Write Collector

This block is a write-only slave on a simple host bus. It assembles a 128-bit descriptor-update register from narrower host stores, each either 32 or 64 bits wide. Parts that arrive before the top dword are held in a small collector. A store that carries the top dword always commits the register to the back-end. Because of this rule, software can update the register from several threads without a lock.

The register exists twice in each queue page, and the page is repeated at a fixed stride across the address space. Each commit leaves the block as a single-cycle strobe. The strobe carries the page index, a select bit naming which of the two registers was hit, the 128-bit value, and a flag that says whether every part was present. If any part is missing, the commit sends the current top dword and zeros the lower 96 bits. Four other single-dword registers in each page are not collected. They pass straight through on their own strobe.

Top module: `wide_wr_collector`

## Requirements
- R1: Within one page, 32-bit stores to the dwords at page offsets 0x830, 0x834 and 0x838, followed by a store to 0x83C, produce a commit with all four dwords in place. Dword k of the value is held in bits [32k+31:32k]. The full flag is 1 and the select is 0.
- R2: A 64-bit store at page offset 0xA10 supplies dwords 0 (data[31:0]) and 1 (data[63:32]). A 64-bit store at 0xA18 supplies dwords 2 and 3 and commits the register. The commit has the full flag set and select 1.
- R3: Any accepted store that carries the top dword commits one cycle later. The commit strobe is high for exactly that one cycle, and the top 32 bits of the value are the top dword of that same store.
- R4: When the held parts and the current store together do not cover all four dwords, the commit still happens. Its low 96 bits are zero and the full flag is 0.
- R5: Some stores are dropped with no effect on any output or on the collector contents. These are: a 64-bit store whose offset is not a multiple of 8, any store whose address bits [1:0] are not zero, and any store to an unmapped offset.
- R6: The page index is the address divided by the stride (default 0x2000). Commits and plain strobes report this index.
- R7: Every commit empties the collector. A later top-dword store with no new parts therefore gives a commit with the full flag at 0.
- R8: A partial store aimed at a different page or register than the parts already held discards those parts before it is stored.
- R9: 32-bit stores to page offsets 0x180, 0x200, 0x400 and 0x420 give a one-cycle plain strobe one cycle later. The strobe reports index 0, 1, 2 or 3 in that order, along with the page and data[31:0].
- R10: While reset is active, neither strobe is high. Reset also empties the collector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Host store valid |
| wr_wide_i | input | 1 | 1 = 64-bit store, 0 = 32-bit store |
| wr_addr_i | input | ADDR_W (17) | Byte address: page index above the stride bits, offset below them |
| wr_data_i | input | 64 | Store data; a 32-bit store uses [31:0] |
| commit_o | output | 1 | One-cycle commit strobe |
| commit_full_o | output | 1 | 1 when all four dwords were supplied |
| commit_sel_o | output | 1 | 0 for the register at 0x830, 1 for the register at 0xA10 |
| commit_page_o | output | PAGE_W (4) | Page index of the commit |
| commit_data_o | output | 128 | Committed register value |
| plain_wr_o | output | 1 | One-cycle strobe for a single-dword register |
| plain_idx_o | output | 2 | Which single-dword register was written |
| plain_page_o | output | PAGE_W (4) | Page index of the plain store |
| plain_data_o | output | 32 | Plain store data |

## Verification
The assertions run on every cycle and check the following:
- commits appear only after a valid store;
- the top dword and the page index of a commit match the store that caused it;
- an incomplete commit always has its low 96 bits at zero;
- misaligned stores never raise a strobe;
- reset keeps both strobes low.

Some behaviour depends on the history of stores and only the bench's scenarios can show it: correct merging of collected parts, emptying after a commit or a reset, and discarding of stale parts when the page or register changes.

// File: rtl/wwc_pkg.sv
package wwc_pkg;
  localparam int unsigned DW_W    = 32;
  localparam int unsigned N_DW    = 4;
  localparam int unsigned BUS_W   = 64;
  localparam int unsigned REG_W   = DW_W * N_DW;
  localparam int unsigned N_PLAIN = 4;

  typedef struct packed {
    logic             hit_wide;
    logic             sel;
    logic [N_DW-1:0]  part_mask;
    logic             hit_plain;
    logic [1:0]       plain_idx;
  } dec_t;
endpackage

// File: rtl/wwc_decode.sv
module wwc_decode
  import wwc_pkg::*;
#(
  parameter int unsigned OFS_W      = 13,
  parameter int unsigned PAGE_W     = 4,
  parameter int unsigned WIDE_OFS0  = 32'h830,
  parameter int unsigned WIDE_OFS1  = 32'hA10,
  parameter int unsigned PLAIN_OFS0 = 32'h180,
  parameter int unsigned PLAIN_OFS1 = 32'h200,
  parameter int unsigned PLAIN_OFS2 = 32'h400,
  parameter int unsigned PLAIN_OFS3 = 32'h420,
  localparam int unsigned ADDR_W    = OFS_W + PAGE_W
) (
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o,
  output logic [PAGE_W-1:0] page_o
);
  localparam logic [OFS_W-1:0] W0 = OFS_W'(WIDE_OFS0);
  localparam logic [OFS_W-1:0] W1 = OFS_W'(WIDE_OFS1);
  localparam logic [N_PLAIN-1:0][OFS_W-1:0] POFS = {
    OFS_W'(PLAIN_OFS3), OFS_W'(PLAIN_OFS2), OFS_W'(PLAIN_OFS1), OFS_W'(PLAIN_OFS0)};

  logic [OFS_W-1:0]   ofs;
  logic               aligned;
  logic               hit0, hit1;
  logic [1:0]         dw;
  logic [N_PLAIN-1:0] pmatch;

  assign ofs    = addr_i[OFS_W-1:0];
  assign page_o = addr_i[ADDR_W-1:OFS_W];
  assign dw     = ofs[3:2];
  // 64-bit stores must sit on an 8-byte boundary
  assign aligned = (ofs[1:0] == 2'b00) && (!wide_i || !ofs[2]);
  assign hit0    = ofs[OFS_W-1:4] == W0[OFS_W-1:4];
  assign hit1    = ofs[OFS_W-1:4] == W1[OFS_W-1:4];

  for (genvar i = 0; i < N_PLAIN; i++) begin : g_plain
    assign pmatch[i] = !wide_i && (ofs == POFS[i]);
  end

  always_comb begin
    dec_o           = '0;
    dec_o.hit_wide  = aligned && (hit0 || hit1);
    dec_o.sel       = hit1;
    dec_o.part_mask = wide_i ? (dw[1] ? 4'b1100 : 4'b0011) : (4'b0001 << dw);
    dec_o.hit_plain = aligned && (|pmatch);
    for (int i = N_PLAIN - 1; i >= 0; i--) begin
      if (pmatch[i]) dec_o.plain_idx = 2'(i);
    end
  end
endmodule

// File: rtl/wwc_collector.sv
module wwc_collector
  import wwc_pkg::*;
#(
  parameter int unsigned PAGE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wide_i,
  input  logic              sel_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [N_DW-1:0]   part_mask_i,
  input  logic [BUS_W-1:0]  data_i,
  output logic              commit_o,
  output logic              full_o,
  output logic              sel_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [REG_W-1:0]  data_o
);
  logic [N_DW-1:0][DW_W-1:0]   new_lane;
  logic [N_DW-2:0][DW_W-1:0]   col_q, merged;
  logic [N_DW-1:0]             vmask_q, base, total;
  logic [PAGE_W-1:0]           own_page_q;
  logic                        own_sel_q;
  logic                        same;

  // odd lanes of a 64-bit store take the upper half of the bus
  for (genvar k = 0; k < N_DW; k++) begin : g_lane
    if (k % 2 == 1) begin : g_odd
      assign new_lane[k] = wide_i ? data_i[BUS_W-1:DW_W] : data_i[DW_W-1:0];
    end else begin : g_even
      assign new_lane[k] = data_i[DW_W-1:0];
    end
  end

  always_comb begin
    // R8: parts held for another page or register are dropped
    same  = (vmask_q != '0) && (own_page_q == page_i) && (own_sel_q == sel_i);
    base  = same ? vmask_q : '0;
    total = base | part_mask_i;
    for (int k = 0; k < N_DW - 1; k++) begin
      merged[k] = part_mask_i[k] ? new_lane[k] : (same ? col_q[k] : '0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q      <= '0;
      vmask_q    <= '0;
      own_page_q <= '0;
      own_sel_q  <= 1'b0;
      commit_o   <= 1'b0;
      full_o     <= 1'b0;
      sel_o      <= 1'b0;
      page_o     <= '0;
      data_o     <= '0;
    end else begin
      commit_o <= 1'b0;
      if (req_i) begin
        if (part_mask_i[N_DW-1]) begin
          // R3/R4: top dword always commits; zero-fill when incomplete
          commit_o <= 1'b1;
          full_o   <= &total;
          sel_o    <= sel_i;
          page_o   <= page_i;
          data_o   <= (&total) ? {new_lane[N_DW-1], merged}
                               : {new_lane[N_DW-1], {(REG_W-DW_W){1'b0}}};
          vmask_q  <= '0;  // R7
          col_q    <= '0;
        end else begin
          vmask_q    <= total;
          col_q      <= merged;
          own_page_q <= page_i;
          own_sel_q  <= sel_i;
        end
      end
    end
  end
endmodule

// File: rtl/wwc_plain.sv
module wwc_plain
  import wwc_pkg::*;
#(
  parameter int unsigned PAGE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        idx_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [DW_W-1:0]   data_i,
  output logic              wr_o,
  output logic [1:0]        idx_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [DW_W-1:0]   data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_o   <= 1'b0;
      idx_o  <= '0;
      page_o <= '0;
      data_o <= '0;
    end else begin
      wr_o <= req_i;  // R9
      if (req_i) begin
        idx_o  <= idx_i;
        page_o <= page_i;
        data_o <= data_i;
      end
    end
  end
endmodule

// File: rtl/wide_wr_collector.sv
module wide_wr_collector
  import wwc_pkg::*;
#(
  parameter int unsigned PAGE_W      = 4,
  parameter int unsigned PAGE_STRIDE = 32'h2000,
  parameter int unsigned WIDE_OFS0   = 32'h830,
  parameter int unsigned WIDE_OFS1   = 32'hA10,
  parameter int unsigned PLAIN_OFS0  = 32'h180,
  parameter int unsigned PLAIN_OFS1  = 32'h200,
  parameter int unsigned PLAIN_OFS2  = 32'h400,
  parameter int unsigned PLAIN_OFS3  = 32'h420,
  localparam int unsigned OFS_W      = $clog2(PAGE_STRIDE),
  localparam int unsigned ADDR_W     = OFS_W + PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic              wr_wide_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [63:0]       wr_data_i,
  output logic              commit_o,
  output logic              commit_full_o,
  output logic              commit_sel_o,
  output logic [PAGE_W-1:0] commit_page_o,
  output logic [127:0]      commit_data_o,
  output logic              plain_wr_o,
  output logic [1:0]        plain_idx_o,
  output logic [PAGE_W-1:0] plain_page_o,
  output logic [31:0]       plain_data_o
);
  dec_t              dec;
  logic [PAGE_W-1:0] page;

  wwc_decode #(
    .OFS_W(OFS_W), .PAGE_W(PAGE_W),
    .WIDE_OFS0(WIDE_OFS0), .WIDE_OFS1(WIDE_OFS1),
    .PLAIN_OFS0(PLAIN_OFS0), .PLAIN_OFS1(PLAIN_OFS1),
    .PLAIN_OFS2(PLAIN_OFS2), .PLAIN_OFS3(PLAIN_OFS3)
  ) u_dec (
    .wide_i (wr_wide_i),
    .addr_i (wr_addr_i),
    .dec_o  (dec),
    .page_o (page)
  );

  wwc_collector #(.PAGE_W(PAGE_W)) u_col (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (wr_valid_i && dec.hit_wide),
    .wide_i      (wr_wide_i),
    .sel_i       (dec.sel),
    .page_i      (page),
    .part_mask_i (dec.part_mask),
    .data_i      (wr_data_i),
    .commit_o    (commit_o),
    .full_o      (commit_full_o),
    .sel_o       (commit_sel_o),
    .page_o      (commit_page_o),
    .data_o      (commit_data_o)
  );

  wwc_plain #(.PAGE_W(PAGE_W)) u_plain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (wr_valid_i && dec.hit_plain),
    .idx_i  (dec.plain_idx),
    .page_i (page),
    .data_i (wr_data_i[31:0]),
    .wr_o   (plain_wr_o),
    .idx_o  (plain_idx_o),
    .page_o (plain_page_o),
    .data_o (plain_data_o)
  );
endmodule

// File: rtl/wwc_checker.sv
module wwc_checker #(
  parameter int unsigned PAGE_W = 4,
  parameter int unsigned ADDR_W = 17
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_valid_i,
  input logic              wr_wide_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [63:0]       wr_data_i,
  input logic              commit_o,
  input logic              commit_full_o,
  input logic [PAGE_W-1:0] commit_page_o,
  input logic [127:0]      commit_data_o,
  input logic              plain_wr_o
);
  AST_COMMIT_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(wr_valid_i));  // R3

  AST_TOP_DWORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> commit_data_o[127:96] ==
      $past(wr_wide_i ? wr_data_i[63:32] : wr_data_i[31:0]));  // R3

  AST_ZERO_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_o && !commit_full_o) |-> commit_data_o[95:0] == '0);  // R4

  AST_PAGE_INDEX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> commit_page_o == $past(wr_addr_i[ADDR_W-1 -: PAGE_W]));  // R6

  AST_MISALIGNED_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_valid_i && ((wr_wide_i && wr_addr_i[2]) || wr_addr_i[1:0] != 2'b00))
      |-> !commit_o && !plain_wr_o);  // R5

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (!commit_o && !plain_wr_o);  // R10
    end
  end
endmodule

bind wide_wr_collector wwc_checker #(.PAGE_W(PAGE_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_valid_i    (wr_valid_i),
  .wr_wide_i     (wr_wide_i),
  .wr_addr_i     (wr_addr_i),
  .wr_data_i     (wr_data_i),
  .commit_o      (commit_o),
  .commit_full_o (commit_full_o),
  .commit_page_o (commit_page_o),
  .commit_data_o (commit_data_o),
  .plain_wr_o    (plain_wr_o)
);

// File: tb/wide_wr_collector_tb.sv
module wide_wr_collector_tb_top;
  localparam int unsigned PAGE_W = 4;
  localparam int unsigned ADDR_W = 17;

  typedef struct packed {
    logic              wide;
    logic [ADDR_W-1:0] addr;
    logic [63:0]       data;
    logic              ec;
    logic              ef;
    logic [127:0]      ed;
    logic [3:0]        pg;
    logic              sel;
    logic              ep;
    logic [1:0]        pidx;
    logic [3:0]        req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    // R1: four dword stores, page 1, register 0
    '{1'b0, 17'h02830, 64'h11111111, 1'b0, 1'b0, 128'h0, 4'd1, 1'b0, 1'b0, 2'd0, 4'd1},
    '{1'b0, 17'h02834, 64'h22222222, 1'b0, 1'b0, 128'h0, 4'd1, 1'b0, 1'b0, 2'd0, 4'd1},
    '{1'b0, 17'h02838, 64'h33333333, 1'b0, 1'b0, 128'h0, 4'd1, 1'b0, 1'b0, 2'd0, 4'd1},
    '{1'b0, 17'h0283C, 64'h44444444, 1'b1, 1'b1, 128'h44444444_33333333_22222222_11111111, 4'd1, 1'b0, 1'b0, 2'd0, 4'd1},
    // R7: collector empty after commit
    '{1'b0, 17'h0283C, 64'h55555555, 1'b1, 1'b0, 128'h55555555_00000000_00000000_00000000, 4'd1, 1'b0, 1'b0, 2'd0, 4'd7},
    // R2: two 64-bit stores, page 2, register 1
    '{1'b1, 17'h04A10, 64'hBBBBBBBB_AAAAAAAA, 1'b0, 1'b0, 128'h0, 4'd2, 1'b1, 1'b0, 2'd0, 4'd2},
    '{1'b1, 17'h04A18, 64'hDDDDDDDD_CCCCCCCC, 1'b1, 1'b1, 128'hDDDDDDDD_CCCCCCCC_BBBBBBBB_AAAAAAAA, 4'd2, 1'b1, 1'b0, 2'd0, 4'd2},
    // R8: page changes discard held parts
    '{1'b0, 17'h06830, 64'h12345678, 1'b0, 1'b0, 128'h0, 4'd3, 1'b0, 1'b0, 2'd0, 4'd8},
    '{1'b0, 17'h06834, 64'h9ABCDEF0, 1'b0, 1'b0, 128'h0, 4'd3, 1'b0, 1'b0, 2'd0, 4'd8},
    '{1'b0, 17'h08838, 64'hAAAA0000, 1'b0, 1'b0, 128'h0, 4'd4, 1'b0, 1'b0, 2'd0, 4'd8},
    '{1'b0, 17'h06838, 64'h33330000, 1'b0, 1'b0, 128'h0, 4'd3, 1'b0, 1'b0, 2'd0, 4'd8},
    '{1'b0, 17'h0683C, 64'h66666666, 1'b1, 1'b0, 128'h66666666_00000000_00000000_00000000, 4'd3, 1'b0, 1'b0, 2'd0, 4'd8},
    // R9: plain single-dword registers
    '{1'b0, 17'h0A200, 64'hCAFEF00D, 1'b0, 1'b0, 128'h0, 4'd5, 1'b0, 1'b1, 2'd1, 4'd9},
    '{1'b0, 17'h00420, 64'h0000BEEF, 1'b0, 1'b0, 128'h0, 4'd0, 1'b0, 1'b1, 2'd3, 4'd9},
    // R5: dropped stores leave the collector alone
    '{1'b0, 17'h02830, 64'h01010101, 1'b0, 1'b0, 128'h0, 4'd1, 1'b0, 1'b0, 2'd0, 4'd5},
    '{1'b1, 17'h02834, 64'hEEEEEEEE_EEEEEEEE, 1'b0, 1'b0, 128'h0, 4'd1, 1'b0, 1'b0, 2'd0, 4'd5},
    '{1'b1, 17'h0283C, 64'hEEEEEEEE_EEEEEEEE, 1'b0, 1'b0, 128'h0, 4'd1, 1'b0, 1'b0, 2'd0, 4'd5},
    '{1'b0, 17'h02831, 64'hEEEEEEEE, 1'b0, 1'b0, 128'h0, 4'd1, 1'b0, 1'b0, 2'd0, 4'd5},
    '{1'b0, 17'h02838, 64'h03030303, 1'b0, 1'b0, 128'h0, 4'd1, 1'b0, 1'b0, 2'd0, 4'd5},
    '{1'b0, 17'h0283C, 64'h04040404, 1'b1, 1'b0, 128'h04040404_00000000_00000000_00000000, 4'd1, 1'b0, 1'b0, 2'd0, 4'd5}
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_valid_i = 1'b0;
  logic              wr_wide_i = 1'b0;
  logic [ADDR_W-1:0] wr_addr_i = '0;
  logic [63:0]       wr_data_i = '0;
  logic              commit_o, commit_full_o, commit_sel_o, plain_wr_o;
  logic [PAGE_W-1:0] commit_page_o, plain_page_o;
  logic [127:0]      commit_data_o;
  logic [1:0]        plain_idx_o;
  logic [31:0]       plain_data_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  wide_wr_collector dut_i (
    .clk_i, .rst_ni, .wr_valid_i, .wr_wide_i, .wr_addr_i, .wr_data_i,
    .commit_o, .commit_full_o, .commit_sel_o, .commit_page_o, .commit_data_o,
    .plain_wr_o, .plain_idx_o, .plain_page_o, .plain_data_o
  );

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic wide, input logic [ADDR_W-1:0] a, input logic [63:0] d);
    @(negedge clk_i);
    wr_valid_i = 1'b1; wr_wide_i = wide; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_valid_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10: reset state
    chk("R10", {254'b0, commit_o, plain_wr_o}, 256'b0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[i].req);
      put(VECS[i].wide, VECS[i].addr, VECS[i].data);
      chk(tag, {255'b0, commit_o}, {255'b0, VECS[i].ec});
      if (VECS[i].ec)
        chk(tag, {122'b0, commit_full_o, commit_sel_o, commit_page_o, commit_data_o},
                 {122'b0, VECS[i].ef, VECS[i].sel, VECS[i].pg, VECS[i].ed});
      chk(tag, {255'b0, plain_wr_o}, {255'b0, VECS[i].ep});
      if (VECS[i].ep)
        chk(tag, {218'b0, plain_idx_o, plain_page_o, plain_data_o},
                 {218'b0, VECS[i].pidx, VECS[i].pg, VECS[i].data[31:0]});
    end

    // R3: strobe lasts one cycle
    put(1'b0, 17'h1E83C, 64'h0BADCAFE);
    chk("R3", {251'b0, commit_o, commit_page_o}, {251'b0, 1'b1, 4'd15});
    @(negedge clk_i);
    chk("R3", {255'b0, commit_o}, 256'b0);

    // R10: reset empties the collector
    put(1'b0, 17'h02830, 64'h1);
    put(1'b0, 17'h02834, 64'h2);
    put(1'b0, 17'h02838, 64'h3);
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R10", {254'b0, commit_o, plain_wr_o}, 256'b0);
    rst_ni = 1'b1;
    put(1'b0, 17'h0283C, 64'h4);
    chk("R10", {127'b0, commit_o, commit_data_o}, {127'b0, 1'b1, 128'h4 << 96});

    // R5: unmapped offset gives no strobe
    put(1'b0, 17'h02840, 64'h5);
    chk("R5", {254'b0, commit_o, plain_wr_o}, 256'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule